// File: doc/BRIEF.md
# Looping Sample Buffer Streamer

This block plays one sample buffer out of a word-addressed memory into a consumer FIFO, over and over, with no gap between passes. Two configuration fields set the playback: a buffer start address and a buffer length in bytes. A start command begins the loop. An abort command halts it.

Inside, a small state machine works as two chained channels. The reload step (state `RELOAD`) copies the stored start address into the read pointer and reloads the word count from the programmed length. The streaming step (state `STREAM`, then `DRAIN`) reads one 32-bit word per transfer from rising addresses. It sends each word to a single fixed FIFO address, and it only issues a read while the consumer's request input is high. When the last word of a pass has left the pipe, the machine goes back to `RELOAD` and the buffer repeats.

Memory reads return data one cycle after they are issued. A word that arrives while the FIFO reports full is parked in a hold register and written once space appears. Configuration writes never start anything by themselves. A normal sequence is: abort, reprogram, start.

States and transitions:
- `IDLE`: goes to `RELOAD` on start (without abort).
- `RELOAD`: goes to `STREAM`.
- `STREAM`: goes to `DRAIN` when the last read of a pass is issued.
- `DRAIN`: goes to `RELOAD` once the pipe is empty.
- Abort sends any state to `IDLE`.

Top module: `ring_streamer`

## Requirements
- R1: After reset, `busy`, `mem_rd_en` and `fifo_wr_en` are all low.
- R2: A configuration write (`cfg_sel` 0 = start address, 1 = length in bytes, other codes ignored) starts no memory read and leaves `busy` low.
- R3: After start, words are read from the start address with its two low bits cleared, then from each next address in steps of 4. They are written to the FIFO in read order, and `fifo_wr_addr` always equals the parameter `FIFO_ADDR`. At most one read is outstanding.
- R4: A memory read is issued only in a cycle where `fifo_req` is high. While `fifo_req` stays low, no reads occur.
- R5: The programmed length has its two low bits cleared and is then clamped to the range `MIN_BYTES` (20) to `MAX_BYTES` (2000). One pass moves length/4 words.
- R6: After the last word of a pass, reading resumes at the start address, and this repeats without end.
- R7: A start address or length written while streaming takes effect at the next pass boundary. The word count reloads from the programmed value on every pass.
- R8: `fifo_wr_en` is never high while `fifo_full` is high, even when `fifo_req` is still high from the previous cycle. A word held back by a full FIFO is written later, in order, with no loss.
- R9: Abort sends the block to idle within one cycle. It drops any parked word, and no further read or write follows. If abort and start arrive in the same cycle, abort wins.
- R10: `busy` rises the cycle after start and stays high until an abort.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Field select: 0 start address, 1 length in bytes |
| cfg_wdata | input | ADDR_W | Configuration write value |
| start | input | 1 | Start pulse: begins the loop with a reload |
| abort | input | 1 | Abort pulse: stops everything |
| busy | output | 1 | High while the loop runs |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_rd_addr | output | ADDR_W | Memory byte address, word aligned |
| mem_rd_data | input | DATA_W | Read data, valid one cycle after the strobe |
| fifo_req | input | 1 | Consumer request (may lag full by a cycle) |
| fifo_full | input | 1 | Consumer FIFO full |
| fifo_wr_en | output | 1 | FIFO write strobe |
| fifo_wr_addr | output | ADDR_W | Fixed FIFO target address |
| fifo_wr_data | output | DATA_W | FIFO write data |

## Verification
Abort can land in the same cycle in which a parked word would be released to the FIFO. The bench holds `fifo_full` high long enough for a word to be parked. It then drops `fifo_full` in exactly the cycle that abort is pulsed. The result is judged at the ports: no FIFO write may appear in that cycle or in any later one, and `busy` must be low.

A second collision pulses start and abort together while idle. That case must leave `busy` low and issue no read.

// File: rtl/rls_pkg.sv
package rls_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_RELOAD = 2'd1,
        ST_STREAM = 2'd2,
        ST_DRAIN  = 2'd3
    } rls_state_e;

    localparam logic [1:0] SEL_BASE   = 2'd0;
    localparam logic [1:0] SEL_LENGTH = 2'd1;

endpackage

// File: rtl/rls_cfg.sv
module rls_cfg
    import rls_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int MIN_BYTES = 20,
    parameter int MAX_BYTES = 2000
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_wr,
    input  logic [1:0]          cfg_sel,
    input  logic [ADDR_W-1:0]   cfg_wdata,
    output logic [ADDR_W-1:0]   base_addr,
    output logic [ADDR_W-3:0]   word_total
);
    localparam int CNT_W = ADDR_W - 2;
    localparam logic [CNT_W-1:0] MIN_WORDS = CNT_W'(MIN_BYTES / 4);
    localparam logic [CNT_W-1:0] MAX_WORDS = CNT_W'(MAX_BYTES / 4);

    logic [CNT_W-1:0] raw_words;
    logic [CNT_W-1:0] clamped_words;

    // dropping the two low bits rounds the byte length down to whole words
    always_comb begin
        raw_words = cfg_wdata[ADDR_W-1:2];
        if (raw_words < MIN_WORDS)
            clamped_words = MIN_WORDS;
        else if (raw_words > MAX_WORDS)
            clamped_words = MAX_WORDS;
        else
            clamped_words = raw_words;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_addr  <= '0;
            word_total <= MIN_WORDS;
        end else if (cfg_wr) begin
            if (cfg_sel == SEL_BASE)
                base_addr <= {cfg_wdata[ADDR_W-1:2], 2'b00};
            else if (cfg_sel == SEL_LENGTH)
                word_total <= clamped_words;
        end
    end

    AST_COUNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (word_total >= MIN_WORDS) && (word_total <= MAX_WORDS)) else $error("count out of range"); // R5

endmodule

// File: rtl/rls_pipe.sv
module rls_pipe #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              issue,
    input  logic              abort,
    input  logic              fifo_full,
    input  logic [DATA_W-1:0] rd_data,
    output logic              wr_en,
    output logic [DATA_W-1:0] wr_data,
    output logic              empty
);
    logic              inflight_q;
    logic              hold_vld_q;
    logic [DATA_W-1:0] hold_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            inflight_q <= 1'b0;
            hold_vld_q <= 1'b0;
            hold_q     <= '0;
        end else if (abort) begin
            inflight_q <= 1'b0;
            hold_vld_q <= 1'b0;
        end else begin
            inflight_q <= issue;
            if (inflight_q && fifo_full) begin
                hold_q     <= rd_data;
                hold_vld_q <= 1'b1;
            end else if (hold_vld_q && !fifo_full) begin
                hold_vld_q <= 1'b0;
            end
        end
    end

    always_comb begin
        wr_en   = (inflight_q || hold_vld_q) && !fifo_full && !abort;
        wr_data = hold_vld_q ? hold_q : rd_data;
        empty   = !inflight_q && !hold_vld_q;
    end

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_vld_q && $past(hold_vld_q)) |-> $stable(hold_q)) else $error("parked word changed"); // R8
    AST_NO_DOUBLE_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        !(inflight_q && hold_vld_q)) else $error("two words in pipe"); // R3

endmodule

// File: rtl/rls_fsm.sv
module rls_fsm
    import rls_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              abort,
    input  logic              fifo_req,
    input  logic              pipe_empty,
    input  logic [ADDR_W-1:0] base_addr,
    input  logic [ADDR_W-3:0] word_total,
    output logic              issue,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              busy
);
    localparam int CNT_W = ADDR_W - 2;
    localparam logic [ADDR_W-1:0] WORD_STEP = ADDR_W'(4);
    localparam logic [CNT_W-1:0]  ONE_LEFT  = CNT_W'(1);

    rls_state_e        state_q, state_d;
    logic [ADDR_W-1:0] ptr_q;
    logic [CNT_W-1:0]  left_q;

    always_comb begin
        issue = (state_q == ST_STREAM) && fifo_req && pipe_empty
                && (left_q != '0) && !abort;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start && !abort) state_d = ST_RELOAD;
            ST_RELOAD: state_d = abort ? ST_IDLE : ST_STREAM;
            ST_STREAM: begin
                if (abort)
                    state_d = ST_IDLE;
                else if (issue && left_q == ONE_LEFT)
                    state_d = ST_DRAIN;
            end
            ST_DRAIN: begin
                if (abort)
                    state_d = ST_IDLE;
                else if (pipe_empty)
                    state_d = ST_RELOAD;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // read pointer and remaining count: the reload step acts as the control channel
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q  <= '0;
            left_q <= '0;
        end else if (state_q == ST_RELOAD) begin
            ptr_q  <= base_addr;
            left_q <= word_total;
        end else if (issue) begin
            ptr_q  <= ptr_q + WORD_STEP;
            left_q <= left_q - ONE_LEFT;
        end
    end

    // outputs
    always_comb begin
        rd_addr = ptr_q;
        busy    = (state_q != ST_IDLE);
    end

    AST_ABORT_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> (state_q == ST_IDLE)) else $error("abort ignored"); // R9
    AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !abort) |=> busy) else $error("start ignored"); // R10
    AST_RELOAD_BASE: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_RELOAD) && !abort) |=> (rd_addr == $past(base_addr))) else $error("reload address"); // R6
    AST_SINGLE_READ: assert property (@(posedge clk) disable iff (!rst_n)
        issue |=> !issue) else $error("back to back reads"); // R3

endmodule

// File: rtl/ring_streamer.sv
module ring_streamer #(
    parameter int                ADDR_W    = 16,
    parameter int                DATA_W    = 32,
    parameter int                MIN_BYTES = 20,
    parameter int                MAX_BYTES = 2000,
    parameter logic [ADDR_W-1:0] FIFO_ADDR = 16'h4000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [1:0]        cfg_sel,
    input  logic [ADDR_W-1:0] cfg_wdata,
    input  logic              start,
    input  logic              abort,
    output logic              busy,
    output logic              mem_rd_en,
    output logic [ADDR_W-1:0] mem_rd_addr,
    input  logic [DATA_W-1:0] mem_rd_data,
    input  logic              fifo_req,
    input  logic              fifo_full,
    output logic              fifo_wr_en,
    output logic [ADDR_W-1:0] fifo_wr_addr,
    output logic [DATA_W-1:0] fifo_wr_data
);
    localparam int CNT_W = ADDR_W - 2;

    logic [ADDR_W-1:0] base_addr;
    logic [CNT_W-1:0]  word_total;
    logic              issue;
    logic              pipe_empty;

    rls_cfg #(
        .ADDR_W   (ADDR_W),
        .MIN_BYTES(MIN_BYTES),
        .MAX_BYTES(MAX_BYTES)
    ) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_wr    (cfg_wr),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .base_addr (base_addr),
        .word_total(word_total)
    );

    rls_fsm #(
        .ADDR_W(ADDR_W)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .abort     (abort),
        .fifo_req  (fifo_req),
        .pipe_empty(pipe_empty),
        .base_addr (base_addr),
        .word_total(word_total),
        .issue     (issue),
        .rd_addr   (mem_rd_addr),
        .busy      (busy)
    );

    rls_pipe #(
        .DATA_W(DATA_W)
    ) u_pipe (
        .clk      (clk),
        .rst_n    (rst_n),
        .issue    (issue),
        .abort    (abort),
        .fifo_full(fifo_full),
        .rd_data  (mem_rd_data),
        .wr_en    (fifo_wr_en),
        .wr_data  (fifo_wr_data),
        .empty    (pipe_empty)
    );

    always_comb begin
        mem_rd_en    = issue;
        fifo_wr_addr = FIFO_ADDR;
    end

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mem_rd_en && !fifo_wr_en)) else $error("activity while idle"); // R9
    AST_READ_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |-> fifo_req) else $error("read without request"); // R4
    AST_NO_WRITE_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_wr_en |-> !fifo_full) else $error("write into full fifo"); // R8

endmodule

// File: tb/ring_streamer_test.sv
module ring_streamer_test;
    localparam int ADDR_W = 16;
    localparam int DATA_W = 32;
    localparam logic [ADDR_W-1:0] FIFO_ADDR = 16'h4000;
    localparam int LOG_N = 4096;

    // {length in, start in, expected aligned start, expected words per pass}
    localparam logic [63:0] VEC [6] = '{
        {16'd7,    16'h0100, 16'h0100, 16'd5},
        {16'd23,   16'h0203, 16'h0200, 16'd5},
        {16'd45,   16'h0402, 16'h0400, 16'd11},
        {16'd3000, 16'h1000, 16'h1000, 16'd500},
        {16'd2003, 16'h3001, 16'h3000, 16'd500},
        {16'd64,   16'h0FFC, 16'h0FFC, 16'd16}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cfg_wr = 1'b0;
    logic [1:0]        cfg_sel = 2'd0;
    logic [ADDR_W-1:0] cfg_wdata = '0;
    logic              start = 1'b0;
    logic              abort = 1'b0;
    logic              busy;
    logic              mem_rd_en;
    logic [ADDR_W-1:0] mem_rd_addr;
    logic [DATA_W-1:0] mem_rd_data = '0;
    logic              fifo_req = 1'b1;
    logic              fifo_full = 1'b0;
    logic              fifo_wr_en;
    logic [ADDR_W-1:0] fifo_wr_addr;
    logic [DATA_W-1:0] fifo_wr_data;

    int n_checks = 0;
    int n_fail = 0;
    int wr_cnt = 0;
    int rd_cnt = 0;
    int err_req = 0;
    int err_full = 0;
    int err_addr = 0;
    logic [DATA_W-1:0] wlog [LOG_N];

    logic       stall_en = 1'b0;
    logic       force_full = 1'b0;
    logic       req_gate = 1'b1;
    logic [7:0] lfsr = 8'hA7;

    always #4 clk = ~clk;

    ring_streamer #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .FIFO_ADDR(FIFO_ADDR)) uut (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .start(start), .abort(abort), .busy(busy), .mem_rd_en(mem_rd_en),
        .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data), .fifo_req(fifo_req),
        .fifo_full(fifo_full), .fifo_wr_en(fifo_wr_en), .fifo_wr_addr(fifo_wr_addr),
        .fifo_wr_data(fifo_wr_data)
    );

    function automatic logic [DATA_W-1:0] pat(input logic [ADDR_W-1:0] a);
        return {16'hC0DE, a};
    endfunction

    // memory with one-cycle read latency
    always @(posedge clk) if (mem_rd_en) mem_rd_data <= pat(mem_rd_addr);

    // consumer: request lags full by one cycle
    always @(negedge clk) begin
        fifo_req  <= req_gate & ~fifo_full;
        fifo_full <= force_full | (stall_en & lfsr[0] & lfsr[3]);
        lfsr      <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    end

    // monitor, sampled just before the rising edge
    always begin
        @(negedge clk);
        #3;
        if (mem_rd_en) begin
            rd_cnt++;
            if (!fifo_req) err_req++;
        end
        if (fifo_wr_en) begin
            if (fifo_full) err_full++;
            if (fifo_wr_addr != FIFO_ADDR) err_addr++;
            if (wr_cnt < LOG_N) wlog[wr_cnt] = fifo_wr_data;
            wr_cnt++;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [1:0] sel, input logic [ADDR_W-1:0] val);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_sel = sel; cfg_wdata = val;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic pulse_start();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
    endtask

    task automatic pulse_abort();
        @(negedge clk); abort = 1'b1;
        @(negedge clk); abort = 1'b0;
    endtask

    task automatic wait_writes(input int target);
        for (int c = 0; c < 30000 && wr_cnt < target; c++) @(negedge clk);
        #5;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", wr_cnt, 0);
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #3;
        // R1 reset state
        check(!busy && !mem_rd_en && !fifo_wr_en, "R1", "reset outputs",
              {busy, mem_rd_en, fifo_wr_en}, 0);
        check(fifo_wr_addr == FIFO_ADDR, "R3", "fixed fifo address", fifo_wr_addr, FIFO_ADDR);

        // table-driven passes: clamp, alignment, ordering, looping
        for (int v = 0; v < 6; v++) begin
            logic [15:0] len_in, st_in, st_exp, words;
            int base, rd0, bad, first_bad;
            logic [31:0] got, exp;
            {len_in, st_in, st_exp, words} = VEC[v];
            pulse_abort();
            repeat (3) @(negedge clk);
            stall_en = v[0];
            cfg_write(2'd1, len_in);
            cfg_write(2'd0, st_in);
            rd0 = rd_cnt;
            repeat (20) @(negedge clk);
            #3;
            check(rd_cnt == rd0 && !busy, "R2", "config write started nothing", rd_cnt - rd0, 0);
            base = wr_cnt;
            pulse_start();
            repeat (3) @(negedge clk);
            #3;
            check(busy, "R10", "busy after start", busy, 1);
            wait_writes(base + 2 * words + 2);
            bad = 0; first_bad = -1; got = 0; exp = 0;
            for (int i = 0; i < 2 * words + 2; i++) begin
                logic [31:0] e;
                e = pat(st_exp + 16'(4 * (i % words)));
                if (base + i >= LOG_N || wlog[base + i] != e) begin
                    if (first_bad < 0) begin
                        first_bad = i;
                        exp = e;
                        got = (base + i < LOG_N) ? wlog[base + i] : 32'hDEAD;
                    end
                    bad++;
                end
            end
            // R3 order, R5 clamp to words per pass, R6 wrap to start
            check(bad == 0, "R3 R5 R6", $sformatf("vector %0d word %0d", v, first_bad), got, exp);
            check(busy, "R10", "busy held while looping", busy, 1);
        end
        stall_en = 1'b0;

        // R7: reprogram while streaming, effect at next pass
        begin
            int base, k, bad;
            pulse_abort();
            cfg_write(2'd1, 16'd20);
            cfg_write(2'd0, 16'h0100);
            base = wr_cnt;
            pulse_start();
            wait_writes(base + 2);
            cfg_write(2'd0, 16'h0300);
            cfg_write(2'd1, 16'd32);
            wait_writes(base + 40);
            k = -1; bad = 0;
            for (int i = 0; i < 40; i++)
                if (k < 0 && wlog[base + i][15:0] >= 16'h0300) k = i;
            for (int i = 0; i < 40; i++) begin
                logic [31:0] e;
                if (k < 0 || i < k) e = pat(16'h0100 + 16'(4 * (i % 5)));
                else e = pat(16'h0300 + 16'(4 * ((i - k) % 8)));
                if (wlog[base + i] != e) bad++;
            end
            check(k > 0 && (k % 5) == 0 && k <= 10, "R7", "switch at pass boundary", k, 5);
            check(bad == 0, "R7", "old then new sequence", bad, 0);
        end

        // R8 then R9: park a word behind full, then abort as full drops
        begin
            int c0, c1, r1;
            @(negedge clk); force_full = 1'b1;
            repeat (3) @(negedge clk);
            #3;
            c0 = wr_cnt;
            repeat (12) @(negedge clk);
            #3;
            check(wr_cnt == c0, "R8", "no write while full", wr_cnt - c0, 0);
            @(negedge clk);
            c1 = wr_cnt; r1 = rd_cnt;
            abort = 1'b1; force_full = 1'b0;
            @(negedge clk);
            abort = 1'b0;
            repeat (30) @(negedge clk);
            #3;
            check(wr_cnt == c1, "R9", "parked word dropped on abort", wr_cnt - c1, 0);
            check(rd_cnt == r1 && !busy, "R9", "idle after abort", rd_cnt - r1, 0);
        end

        // R9: start and abort together while idle
        begin
            int r0;
            r0 = rd_cnt;
            @(negedge clk); start = 1'b1; abort = 1'b1;
            @(negedge clk); start = 1'b0; abort = 1'b0;
            repeat (5) @(negedge clk);
            #3;
            check(!busy && rd_cnt == r0, "R9", "abort wins over start", busy, 0);
        end

        // R4: no reads while request low
        begin
            int r0, base;
            cfg_write(2'd1, 16'd20);
            cfg_write(2'd0, 16'h0500);
            req_gate = 1'b0;
            repeat (2) @(negedge clk);
            r0 = rd_cnt; base = wr_cnt;
            pulse_start();
            repeat (20) @(negedge clk);
            #3;
            check(rd_cnt == r0 && busy, "R4", "stall while request low", rd_cnt - r0, 0);
            req_gate = 1'b1;
            wait_writes(base + 3);
            check(wlog[base] == pat(16'h0500), "R3", "first word at start", wlog[base], pat(16'h0500));
            pulse_abort();
        end

        check(err_req == 0, "R4", "reads without request", err_req, 0);
        check(err_full == 0, "R8", "writes while full", err_full, 0);
        check(err_addr == 0, "R3", "fifo address changed", err_addr, 0);

        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end
endmodule